// File: doc/BRIEF.md
# Bus Activity Monitor Channel

This block watches one stream of bus events and turns it into a periodic activity figure. An event prescaler divides the raw event pulses. Each time it wraps, a programmable weight is added to the activity count for the current sampling period. At every period boundary the count is compared against a raw upper and lower threshold, folded into an exponential moving average, and then cleared. The new average is compared against its own pair of thresholds.

Runs of back-to-back periods above or below the raw thresholds are counted, and a status bit is raised after a programmed run length. Average crossings raise their own status bits. All status bits are sticky and are cleared by writing one. The interrupt output is the OR of every pending status bit whose enable is set, and it serves as the channel's bit in a chip-level status word.

Software configures the thresholds, weight, window shift and run lengths through a 32-bit word-addressed register port. It seeds the average, enables sampling, and reacts to the interrupt by reading the average. The period boundary comes from an external timing strobe.

Top module: `act_watch_chan`

## Requirements
- R1: After reset every register, the average, the status bits and the interrupt are zero, and every readable address returns zero.
- R2: The register map by byte address is 0x00 control, 0x04 raw upper threshold, 0x08 raw lower threshold, 0x0C average seed, 0x10 average upper threshold, 0x14 average lower threshold, 0x18 weight, 0x20 average, and 0x24 status. Control, the thresholds and the weight read back as written. Both 0x0C and 0x20 read the running average.
- R3: The control fields are: bit 31 master enable; bit 18 periodic sampling; bits 12:10 shift K; bits 28:26 above-run length minus one; bits 25:23 below-run length minus one; bit 30 above-run interrupt enable; bit 29 below-run interrupt enable; bit 21 average-above enable; bit 20 average-below enable. While the channel is enabled, every PRESCALE-th event adds the weight to the period count. An event in the strobe cycle belongs to the closing period. The prescaler is not cleared at period ends, while the count is.
- R4: At a period end (strobe while enabled and periodic), the average becomes avg + ((count - avg) >>> (K+1)), using signed arithmetic that rounds toward minus infinity. Writing 0x0C loads the average directly, and this takes precedence over a same-cycle period update.
- R5: Status bit 31 is set at the period end that completes N consecutive periods with count strictly greater than the upper threshold, where N is the above-run field plus one. The run restarts from zero after firing and at any period that is not above the threshold.
- R6: Status bit 30 is set in the same way for N consecutive periods with count strictly less than the lower threshold, where N is the below-run field plus one.
- R7: At a period end, status bit 29 is set if the new average is strictly above the average upper threshold, and bit 28 is set if it is strictly below the average lower threshold. Status reads as bits 31:28 of 0x24, with all other bits zero.
- R8: Writing 0x24 clears each status bit written as one. A bit set by a period end in the same cycle stays set.
- R9: The interrupt equals the OR of status bits 31, 30, 29 and 28 gated by control bits 30, 29, 21 and 20 respectively. Status is set regardless of enables.
- R10: With the master enable clear, events and strobes are ignored and all state is kept. With the master enable set and periodic sampling clear, events still accumulate but strobes are ignored.
- R11: Writes to 0x20 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt | input | 1 | One activity event per cycle when high |
| tick | input | 1 | Sampling period boundary strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq | output | 1 | Enabled pending status, channel global bit |

## Verification
Two collisions matter. The first is a status clear written in the same cycle as a period end that sets that very bit. The bench drives the strobe and a clear-all write together on an above-threshold period and expects the bit to survive. The second is a seed write landing on a period end, where the written value must win. The bench also checks that an event arriving in the strobe cycle counts toward the closing period, by forcing the prescaler wrap onto that cycle and judging the result through the average.

// File: rtl/act_watch_chan.sv
module act_watch_chan #(
  parameter int PRESCALE = 256,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          irq
);
  localparam int PSW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PSW-1:0] PS_LAST = PSW'(PRESCALE - 1);

  logic [31:0] ctrl, wm_hi, wm_lo, avg_hi, avg_lo, weight, avg, cnt;
  logic [PSW-1:0] psc;
  logic [2:0] run_hi, run_lo;
  logic [3:0] stat;

  wire en   = ctrl[31];
  wire wrap = en & evt & (psc == PS_LAST);
  wire pend = en & ctrl[18] & tick;
  wire [31:0] cnt_nx = cnt + (wrap ? weight : 32'd0);
  wire [3:0]  shamt = {1'b0, ctrl[12:10]} + 4'd1;

  logic signed [32:0] diff, step;
  assign diff = $signed({1'b0, cnt_nx}) - $signed({1'b0, avg});
  assign step = diff >>> shamt;
  wire [31:0] avg_nx = avg + step[31:0];

  wire hi_hit  = cnt_nx > wm_hi;
  wire lo_hit  = cnt_nx < wm_lo;
  wire fire_hi = pend & hi_hit & (run_hi >= ctrl[28:26]);
  wire fire_lo = pend & lo_hit & (run_lo >= ctrl[25:23]);
  wire [3:0] set = {fire_hi, fire_lo, pend & (avg_nx > avg_hi), pend & (avg_nx < avg_lo)};

  wire wr_stat = wr_en & (addr == AW'(8'h24));
  wire wr_seed = wr_en & (addr == AW'(8'h0C));
  wire [3:0] clr = wr_stat ? wdata[31:28] : 4'd0;

  assign irq = |(stat & {ctrl[30], ctrl[29], ctrl[21], ctrl[20]});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; wm_hi <= '0; wm_lo <= '0; avg_hi <= '0; avg_lo <= '0;
      weight <= '0; avg <= '0; cnt <= '0; psc <= '0;
      run_hi <= '0; run_lo <= '0; stat <= '0;
    end else begin
      if (wr_en) begin
        case (addr)
          AW'(8'h00): ctrl   <= wdata;
          AW'(8'h04): wm_hi  <= wdata;
          AW'(8'h08): wm_lo  <= wdata;
          AW'(8'h10): avg_hi <= wdata;
          AW'(8'h14): avg_lo <= wdata;
          AW'(8'h18): weight <= wdata;
          default: ;
        endcase
      end
      if (en & evt) psc <= wrap ? '0 : psc + 1'b1;
      cnt <= pend ? 32'd0 : cnt_nx;
      if (wr_seed) avg <= wdata;
      else if (pend) avg <= avg_nx;
      if (pend) begin
        run_hi <= (hi_hit & ~fire_hi) ? run_hi + 3'd1 : 3'd0;
        run_lo <= (lo_hit & ~fire_lo) ? run_lo + 3'd1 : 3'd0;
      end
      stat <= (stat & ~clr) | set;
    end
  end

  always_comb begin
    case (addr)
      AW'(8'h00): rdata = ctrl;
      AW'(8'h04): rdata = wm_hi;
      AW'(8'h08): rdata = wm_lo;
      AW'(8'h0C): rdata = avg;
      AW'(8'h10): rdata = avg_hi;
      AW'(8'h14): rdata = avg_lo;
      AW'(8'h18): rdata = weight;
      AW'(8'h20): rdata = avg;
      AW'(8'h24): rdata = {stat, 28'd0};
      default:    rdata = '0;
    endcase
  end

  p_cnt_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pend) |-> cnt == 32'd0);

  p_avg_between_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pend & ~wr_seed) |->
      ((avg >= $past(avg) && avg <= $past(cnt_nx)) ||
       (avg <= $past(avg) && avg >= $past(cnt_nx))));

  p_stat_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & ~$past(stat)) != 4'd0) |-> $past(pend));

  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_stat & wdata[31] & ~fire_hi) |-> !stat[3]);

  p_hold_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> ($stable(cnt) && $stable(psc) && $stable(run_hi) && $stable(run_lo)));
endmodule

// File: tb/act_watch_chan_tb.sv
module act_watch_chan_tb;
  localparam int PS = 4;
  localparam logic [31:0] CFG = 32'h8000_0000 | 32'h4000_0000 | 32'h2000_0000 |
                                32'h0020_0000 | 32'h0010_0000 | 32'h0004_0000 |
                                (32'd2 << 23);  // K=0, below N=3, above N=1

  logic clk = 0, rst_n = 0, evt = 0, tick = 0, wr_en = 0;
  logic [5:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq;
  int checks = 0, fails = 0, cyc = 0;

  act_watch_chan #(.PRESCALE(PS), .AW(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt(evt), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #2.5 clk = ~clk;

  // events per period, expected average, expected status nibble
  localparam int NROW = 8;
  localparam logic [27:0] ROWS [NROW] = '{
    {8'd8,  16'd32,  4'h0}, {8'd16, 16'd48,  4'h8},
    {8'd0,  16'd24,  4'h0}, {8'd0,  16'd12,  4'h0},
    {8'd0,  16'd6,   4'h5}, {8'd24, 16'd51,  4'h8},
    {8'd40, 16'd105, 4'hA}, {8'd0,  16'd52,  4'h0}};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic period(int n, bit clr);
    for (int i = 0; i < n; i++) begin @(negedge clk); evt = 1; end
    @(negedge clk); evt = 0; tick = 1;
    if (clr) begin wr_en = 1; addr = 6'h24; wdata = 32'hFFFF_FFFF; end
    @(negedge clk); tick = 0; wr_en = 0;
  endtask

  function automatic logic [31:0] f_avg(logic [31:0] a, logic [31:0] c, int s);
    longint d = longint'(c) - longint'(a);
    return a + 32'(d >>> s);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a0, s0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int i = 0; i < 10; i++) begin
      rd(6'(i * 4), v); check("R1 reset read", v, 0);
    end
    check("R1 reset irq", {31'd0, irq}, 0);

    // R2 configuration and readback
    wr(6'h04, 40); wr(6'h08, 16); wr(6'h10, 60); wr(6'h14, 8);
    wr(6'h18, 16); wr(6'h0C, 32); wr(6'h00, CFG);
    rd(6'h00, v); check("R2 ctrl", v, CFG);
    rd(6'h04, v); check("R2 upper", v, 40);
    rd(6'h18, v); check("R2 weight", v, 16);
    rd(6'h20, v); check("R2 avg", v, 32);
    // R11 write to average ignored
    wr(6'h20, 32'h1234); rd(6'h20, v); check("R11 avg write ignored", v, 32);

    // table walk: R4 R5 R6 R7 R9
    for (int r = 0; r < NROW; r++) begin
      period(int'(ROWS[r][27:20]), 0);
      rd(6'h20, v); check("R4 avg row", v, {16'd0, ROWS[r][19:4]});
      rd(6'h24, v); check("R5 R6 R7 status row", v, {ROWS[r][3:0], 28'd0});
      check("R9 irq row", {31'd0, irq}, {31'd0, ROWS[r][3:0] != 0});
      wr(6'h24, 32'hFFFF_FFFF);
    end

    // R5 run restart, N=2
    wr(6'h00, CFG | (32'd1 << 26));
    period(16, 0); rd(6'h24, v); check("R5 first of two", {31'd0, v[31]}, 0);
    period(16, 0); rd(6'h24, v); check("R5 second fires", {31'd0, v[31]}, 1);
    wr(6'h24, 32'hFFFF_FFFF);
    period(16, 0); rd(6'h24, v); check("R5 restart after fire", {31'd0, v[31]}, 0);
    period(16, 0); rd(6'h24, v); check("R5 fires again", {31'd0, v[31]}, 1);

    // R8 set wins over same-cycle clear; partial clear
    wr(6'h00, CFG); wr(6'h24, 32'hFFFF_FFFF);
    period(16, 1); rd(6'h24, v); check("R8 set beats clear", {31'd0, v[31]}, 1);
    s0 = v;
    wr(6'h24, 32'h8000_0000); rd(6'h24, v);
    check("R8 partial clear", v, s0 & 32'h7FFF_FFFF);
    // R9 gating
    wr(6'h24, 32'h7000_0000); period(16, 0);
    wr(6'h00, CFG & ~32'h6030_0000);
    rd(6'h24, v); check("R9 status kept", {31'd0, v[31]}, 1);
    check("R9 irq gated off", {31'd0, irq}, 0);
    wr(6'h00, CFG); wr(6'h24, 32'hFFFF_FFFF);

    // R10 master enable off
    rd(6'h20, a0);
    wr(6'h00, CFG & ~32'h8000_0000);
    period(8, 0); period(0, 0);
    rd(6'h20, v); check("R10 avg held when off", v, a0);
    rd(6'h24, v); check("R10 status held when off", v, 0);
    wr(6'h00, CFG); period(0, 0);
    rd(6'h20, v); check("R10 no events counted when off", v, f_avg(a0, 0, 1));
    // R10 periodic off: counts but ignores strobe
    rd(6'h20, a0);
    wr(6'h00, CFG & ~32'h0004_0000);
    period(12, 0);
    rd(6'h20, v); check("R10 strobe ignored", v, a0);
    wr(6'h00, CFG); period(0, 0);
    rd(6'h20, v); check("R10 counting kept", v, f_avg(a0, 48, 1));

    // R3 prescaler carries across period, event in strobe cycle
    wr(6'h0C, 0);
    period(3, 0); rd(6'h20, v); check("R3 partial prescale", v, 0);
    @(negedge clk); evt = 1; tick = 1;
    @(negedge clk); evt = 0; tick = 0;
    rd(6'h20, v); check("R3 carry and strobe-cycle event", v, 8);

    // R4 seed write beats same-cycle period update
    @(negedge clk); tick = 1; wr_en = 1; addr = 6'h0C; wdata = 77;
    @(negedge clk); tick = 0; wr_en = 0;
    rd(6'h0C, v); check("R4 seed wins", v, 77);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule